// File: doc/BRIEF.md
# Constant-Divisor Reciprocal Divider

This block computes the unsigned quotient of an input word divided by a constant fixed at elaboration time. It uses no iterative divider. The dividend is multiplied once by a precomputed fixed-point reciprocal, the upper half of the double-width product is kept as an estimate, and a short tail of shifts, and in one configuration a subtract-halve-add correction, turns that estimate into the exact floor quotient.

Two configurations are selected by a single parameter. The wide configuration divides a 32-bit dividend by 1234567. Its reciprocal constant is 3000869427, and that constant is one bit short of the precision needed for exactness, so the correction step follows the multiply: the estimate is subtracted from the dividend, the difference is halved, the estimate is added back, and the sum is shifted right by 20. The narrow configuration divides a 16-bit dividend by 12345. It multiplies the zero-extended dividend by 43489 and shifts the 32-bit product right by 29, with no correction. The quotient is as wide as the dividend.

The datapath has three register stages: after the multiply, after the correction, and at the output. A valid flag travels alongside the data, so each accepted dividend produces its quotient exactly three clock cycles later. A new dividend may be presented on every cycle.

Top module: `divconst_recip`

## Requirements
- R1: With NARROW=0, every result equals floor(dividend / 1234567) for any 32-bit unsigned dividend.
- R2: With NARROW=1, every result equals floor(dividend / 12345) for any 16-bit unsigned dividend.
- R3: outValid is high in a cycle exactly when inValid was sampled high at the rising edge three cycles earlier, provided reset was inactive across those edges.
- R4: Dividends presented on consecutive cycles are all accepted, and their quotients appear on consecutive cycles in the same order.
- R5: While outValid is low, outQuotient keeps the value it had on the previous cycle.
- R6: A synchronous active-low reset (rstN low at a rising edge) drives outValid and outQuotient to 0 on the next cycle and discards every dividend still in flight.
- R7: Corner dividends give exact results: 0 gives 0; the all-ones dividend gives 3478 (wide) or 5 (narrow); an exact multiple k*divisor gives k, and k*divisor-1 gives k-1.
- R8: A valid quotient never exceeds floor((2^W - 1) / divisor), where W is the dividend width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | High when inDividend holds a dividend to divide |
| inDividend | input | W (32, or 16 when NARROW=1) | Unsigned dividend |
| outValid | output | 1 | High for one cycle for each finished quotient |
| outQuotient | output | W | Unsigned quotient; holds its value when outValid is low |

## Verification
Both configurations run side by side on the same stimulus. The narrow instance sees the low 16 bits of each dividend. A directed burst of corner dividends goes first: zero, all-ones, exact multiples, and one below and one above a multiple. These separate a correct correction step from an estimate that is off by one at a quotient boundary. The burst is followed by a long random stream with random gaps and frequent exact multiples, which exercises back-to-back issue, ordering and value holding between results. A reset in the middle of a stream shows whether in-flight dividends are really discarded rather than delivered late.

// File: rtl/divconst_pkg.sv
package divconst_pkg;

  // Load strobes from the control to the datapath, one per pipeline stage
  typedef struct packed {
    logic loadMul;   // capture the multiply estimate
    logic loadFix;   // capture the corrected sum
    logic loadOut;   // capture the final quotient
  } stageStrobe_t;

  // Largest quotient that a W-bit dividend can produce
  function automatic longint unsigned quotMax(int unsigned w, longint unsigned d);
    longint unsigned allOnes;
    allOnes = (64'd1 << w) - 64'd1;
    return allOnes / d;
  endfunction

endpackage

// File: rtl/divconst_ctrl.sv
module divconst_ctrl
  import divconst_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);

  logic [STAGES-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validPipe <= '0;
    end else begin
      validPipe <= {validPipe[STAGES-2:0], inValid};
    end
  end

  // Each stage loads only when the token in front of it is valid
  always_comb begin
    strobe.loadMul = inValid;
    strobe.loadFix = validPipe[0];
    strobe.loadOut = validPipe[1];
  end

  assign outValid = validPipe[STAGES-1];

endmodule

// File: rtl/divconst_dp.sv
module divconst_dp
  import divconst_pkg::*;
#(
  parameter int unsigned       W          = 32,
  parameter logic [W-1:0]      MAGIC      = '0,
  parameter int unsigned       POST_SHIFT = 20,
  parameter bit                FIXUP      = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  stageStrobe_t strobe,
  input  logic [W-1:0] inDividend,
  output logic [W-1:0] outQuotient
);

  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] product;
  logic [W-1:0]  estReg;
  logic [W-1:0]  sumReg;
  logic [W-1:0]  sumNext;
  logic [W-1:0]  quotReg;

  // One wide multiply by the precomputed reciprocal
  always_comb begin
    product = {{W{1'b0}}, inDividend} * {{W{1'b0}}, MAGIC};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      estReg <= '0;
    end else if (strobe.loadMul) begin
      estReg <= product[PW-1:W];
    end
  end

  generate
    if (FIXUP) begin : g_fixup
      logic [W-1:0] dividendReg;
      logic [W-1:0] diff;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          dividendReg <= '0;
        end else if (strobe.loadMul) begin
          dividendReg <= inDividend;
        end
      end

      // estimate never exceeds the dividend, so the difference is non-negative
      always_comb begin
        diff    = dividendReg - estReg;
        sumNext = (diff >> 1) + estReg;
      end
    end else begin : g_direct
      always_comb begin
        sumNext = estReg;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumReg <= '0;
    end else if (strobe.loadFix) begin
      sumReg <= sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotReg <= '0;
    end else if (strobe.loadOut) begin
      quotReg <= sumReg >> POST_SHIFT;
    end
  end

  assign outQuotient = quotReg;

endmodule

// File: rtl/divconst_recip.sv
module divconst_recip
  import divconst_pkg::*;
#(
  parameter bit NARROW = 1'b0,
  localparam int unsigned W = NARROW ? 16 : 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inDividend,
  output logic         outValid,
  output logic [W-1:0] outQuotient
);

  localparam longint unsigned DIVISOR    = NARROW ? 64'd12345 : 64'd1234567;
  localparam logic [31:0]     MAGIC32    = NARROW ? 32'd43489 : 32'd3000869427;
  // The product's upper half is kept, so the remaining shift is the total minus W
  localparam int unsigned     POST_SHIFT = NARROW ? (29 - 16) : 20;
  localparam bit              FIXUP      = !NARROW;

  stageStrobe_t strobe;

  divconst_ctrl #(
    .STAGES(3)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  divconst_dp #(
    .W         (W),
    .MAGIC     (MAGIC32[W-1:0]),
    .POST_SHIFT(POST_SHIFT),
    .FIXUP     (FIXUP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inDividend (inDividend),
    .outQuotient(outQuotient)
  );

endmodule

// File: rtl/divconst_chk.sv
module divconst_chk #(
  parameter int unsigned     W       = 32,
  parameter longint unsigned DIVISOR = 64'd1234567
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [W-1:0] inDividend,
  input logic         outValid,
  input logic [W-1:0] outQuotient
);

  localparam longint unsigned MAXQ = divconst_pkg::quotMax(W, DIVISOR);

  // Cycles since reset, saturating at 3, so that $past never reaches into reset
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rstN) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (outValid == $past(inValid, 3)));

  // Covers R1 (wide) and R2 (narrow), depending on the bound instance
  assert_quotient_R1: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && outValid) |->
      (64'(outQuotient) == (64'($past(inDividend, 3)) / DIVISOR)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 2'd2 && !outValid) |-> $stable(outQuotient));

  assert_flush_R6: assert property (@(posedge clk)
    !rstN |=> (!outValid && outQuotient == '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (64'(outQuotient) <= MAXQ));

endmodule

bind divconst_recip divconst_chk #(
  .W      (W),
  .DIVISOR(DIVISOR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inDividend (inDividend),
  .outValid   (outValid),
  .outQuotient(outQuotient)
);

// File: tb/divconst_recip_tb.sv
`timescale 1ns/1ps
module divconst_recip_tb;

  localparam longint unsigned DIV_W = 64'd1234567;
  localparam longint unsigned DIV_N = 64'd12345;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inDividend = '0;
  logic        outValidW;
  logic [31:0] outQuotW;
  logic        outValidN;
  logic [15:0] outQuotN;

  int nChecks = 0;
  int nErrors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  divconst_recip #(.NARROW(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDividend(inDividend),
    .outValid(outValidW), .outQuotient(outQuotW));

  divconst_recip #(.NARROW(1'b1)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDividend(inDividend[15:0]),
    .outValid(outValidN), .outQuotient(outQuotN));

  // Behavioural reference: a queue of accepted inputs, one entry per edge
  bit              refV[$];
  longint unsigned refA[$];
  longint unsigned holdW = 0;
  longint unsigned holdN = 0;
  bit              prevPopValid = 0;

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      refV.delete();
      refA.delete();
      holdW = 0;
      holdN = 0;
      prevPopValid = 0;
    end else begin
      refV.push_back(inValid);
      refA.push_back(64'(inDividend));
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      bit v;
      longint unsigned a;
      longint unsigned aN;
      string tagW;
      string tagN;
      if (refV.size() >= 3) begin
        v = refV.pop_front();
        a = refA.pop_front();
      end else begin
        v = 0;
        a = 0;
      end
      aN = a & 64'hFFFF;
      if (refV.size() < 2 && !v) begin
        // Pipeline not yet refilled after reset
        chk("R6 valid after reset", 64'(outValidW), 0);
        chk("R6 valid after reset narrow", 64'(outValidN), 0);
      end
      chk("R3 wide valid", 64'(outValidW), 64'(v));
      chk("R3 narrow valid", 64'(outValidN), 64'(v));
      if (v) begin
        holdW = a / DIV_W;
        holdN = aN / DIV_N;
        tagW = (a == 0 || a == 64'hFFFF_FFFF || (a % DIV_W) == 0 || ((a + 1) % DIV_W) == 0)
               ? "R7 wide corner" : (prevPopValid ? "R4 wide back-to-back" : "R1 wide quotient");
        tagN = (aN == 0 || aN == 64'hFFFF || (aN % DIV_N) == 0 || ((aN + 1) % DIV_N) == 0)
               ? "R7 narrow corner" : (prevPopValid ? "R4 narrow back-to-back" : "R2 narrow quotient");
        chk(tagW, 64'(outQuotW), holdW);
        chk(tagN, 64'(outQuotN), holdN);
        chk("R8 wide bound", 64'(outQuotW <= 32'd3478), 1);
        chk("R8 narrow bound", 64'(outQuotN <= 16'd5), 1);
      end else begin
        chk("R5 wide hold", 64'(outQuotW), holdW);
        chk("R5 narrow hold", 64'(outQuotN), holdN);
      end
      prevPopValid = v;
    end
  end

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    inValid = 1'b1;
    inDividend = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inDividend = $urandom;
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(4);

    // R7 corner burst, back to back
    send(32'd0);
    send(32'hFFFF_FFFF);
    send(32'd1234567);
    send(32'd1234566);
    send(32'd1234568);
    send(32'd4293824026);   // 3478 * 1234567
    send(32'd4293824025);
    send(32'd12345);
    send(32'd61725);        // 5 * 12345
    send(32'd12344);
    send(32'd65535);
    send(32'hFFFF_FFFE);
    send(32'd2469134);      // 2 * 1234567
    idle(5);

    // Random stream with gaps and exact multiples
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      case ($urandom % 5)
        0: a = 32'(($urandom % 3479) * 1234567);
        1: a = {16'($urandom), 16'(($urandom % 6) * 12345)};
        2: a = 32'(($urandom % 3479) * 1234567) - 32'd1;
        default: a = $urandom;
      endcase
      if (($urandom % 4) != 0) send(a);
      else idle(1);
    end
    idle(5);

    // R6: reset with dividends in flight
    send(32'd4000000000);
    send(32'd7777777);
    send(32'd99999);
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    idle(6);
    send(32'd123456789);
    idle(6);

    finishRun();
  end

endmodule